// File: doc/BRIEF.md
# Saturating Assertion Coverage Counter

This block sits beside an assertion or cover monitor inside an emulated or debugged design. It counts event pulses and stops at its largest value instead of wrapping. The pulses can be failure reports, successful-completion reports, or matches of a plain sequence detector. At the end of a run, a single-cycle end strobe is sampled. If nothing was ever counted, a sticky cover-miss flag is raised.

The event source is chosen by a parameter:

- **Pulse mode:** the external pulse input feeds the counter directly.
- **Sequence mode:** a built-in detector for the two-step pattern "`seq_a`, then `seq_b` one cycle later" feeds the counter. Every match produces its own pulse, including overlapping matches.

A width of one makes the count a simple "seen" bit. When fed with completion pulses, the final count can be compared with the number of transactions a testbench issued. The block is cleared by the same active-low reset as the design it observes. It never relies on an end-of-run liveness rewrite. Coverage comes only from counting detector matches.

Top module: `cov_counter_top`

## Requirements
- R1: While `rst_n` is low, `hit_count` is 0 and `cover_miss` is 0.
- R2: Each rising clock edge at which the selected event is high raises `hit_count` by exactly one, unless the count is already at its maximum. An edge with no event leaves it unchanged.
- R3: `hit_count` stops at 2^CNT_W-1 and never rolls over to zero, however many further events arrive.
- R4: With CNT_W = 1, `hit_count` becomes 1 on the first event and stays 1 afterwards.
- R5: In sequence mode (SRC = SRC_SEQ), a match is counted at the edge where `seq_b` is high and `seq_a` was high at the previous edge.
- R6: In sequence mode, overlapping matches each count. The inputs a, a&b, b on three successive edges give two matches.
- R7: In sequence mode, nothing is counted in these cases:
  - `seq_a` followed by an idle cycle and then `seq_b`;
  - `seq_b` with no `seq_a` the edge before.
- R8: `cover_miss` rises at the edge where `eod_strobe` is high and `hit_count` is 0. The comparison uses the count held before that edge. Once raised, the flag stays high until reset.
- R9: An `eod_strobe` seen while `hit_count` is non-zero leaves `cover_miss` at 0.
- R10: Asserting `rst_n` low clears a raised `cover_miss` and the count.
- R11: In sequence mode, `ev_in` has no effect on `hit_count`. In pulse mode, `seq_a` and `seq_b` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the observed design |
| rst_n | input | 1 | Active-low asynchronous reset, shared with the observed design |
| ev_in | input | 1 | External event pulse (used in pulse mode) |
| seq_a | input | 1 | First term of the built-in two-step detector |
| seq_b | input | 1 | Second term of the built-in two-step detector |
| eod_strobe | input | 1 | Single-cycle end-of-execution strobe |
| hit_count | output | CNT_W | Saturating event count |
| cover_miss | output | 1 | Sticky flag: run ended with a zero count |

## Verification
The assertions take for granted that `eod_strobe` is a one-cycle pulse and that all inputs are synchronous to `clk`. They also take for granted that reset is released only between edges. The stimulus changes every input on the falling clock edge and raises the end strobe for exactly one cycle per scenario. Saturation is reached by streaming more events than the counter can hold. The sequence patterns are spaced so that each expected match count is unambiguous.

// File: rtl/cov_pkg.sv
package cov_pkg;
  typedef enum logic [0:0] {
    SRC_PULSE = 1'b0,
    SRC_SEQ   = 1'b1
  } src_e;
endpackage

// File: rtl/cov_seq_detect.sv
module cov_seq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic first_i,
  input  logic second_i,
  output logic match_o
);
  logic first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= 1'b0;
    else        first_q <= first_i;
  end

  assign match_o = first_q & second_i;

  AST_MATCH_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(first_i)); // R5
  AST_MATCH_NEEDS_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> second_i); // R7
endmodule

// File: rtl/cov_sat_counter.sv
module cov_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max = (cnt_q == MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (ev_i && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && cnt_o != MAX) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_i |=> $stable(cnt_o)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == MAX) |=> (cnt_o == MAX)); // R3
  AST_NEVER_RETURNS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o != '0) |=> (cnt_o != '0)); // R3
endmodule

// File: rtl/cov_miss_flag.sv
module cov_miss_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic end_i,
  input  logic zero_i,
  output logic miss_o
);
  logic miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               miss_q <= 1'b0;
    else if (end_i && zero_i) miss_q <= 1'b1;
  end

  assign miss_o = miss_q;

  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |=> miss_o); // R8
  AST_MISS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_o) |-> ($past(end_i) && $past(zero_i))); // R9
endmodule

// File: rtl/cov_counter_top.sv
module cov_counter_top #(
  parameter int            CNT_W = 4,
  parameter cov_pkg::src_e SRC   = cov_pkg::SRC_PULSE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_in,
  input  logic             seq_a,
  input  logic             seq_b,
  input  logic             eod_strobe,
  output logic [CNT_W-1:0] hit_count,
  output logic             cover_miss
);
  localparam bit USE_SEQ = (SRC == cov_pkg::SRC_SEQ);

  logic seq_hit;
  logic ev_sel;
  logic cnt_zero;

  cov_seq_detect u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .first_i  (seq_a),
    .second_i (seq_b),
    .match_o  (seq_hit)
  );

  assign ev_sel = USE_SEQ ? seq_hit : ev_in;

  cov_sat_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (ev_sel),
    .cnt_o  (hit_count),
    .zero_o (cnt_zero)
  );

  cov_miss_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .end_i  (eod_strobe),
    .zero_i (cnt_zero),
    .miss_o (cover_miss)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (hit_count == '0 && !cover_miss)); // R1
endmodule

// File: tb/cov_counter_top_test.sv
module cov_counter_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_p = 1'b0, a_p = 1'b0, b_p = 1'b0, eod_p = 1'b0;
  logic ev_s = 1'b0, a_s = 1'b0, b_s = 1'b0, eod_s = 1'b0;
  logic ev_1 = 1'b0, eod_1 = 1'b0;
  logic [2:0] cnt_p, cnt_s;
  logic [0:0] cnt_1;
  logic miss_p, miss_s, miss_1;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cov_counter_top #(.CNT_W(3), .SRC(cov_pkg::SRC_PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_p), .seq_a(a_p), .seq_b(b_p),
    .eod_strobe(eod_p), .hit_count(cnt_p), .cover_miss(miss_p));
  cov_counter_top #(.CNT_W(3), .SRC(cov_pkg::SRC_SEQ)) uut_seq (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_s), .seq_a(a_s), .seq_b(b_s),
    .eod_strobe(eod_s), .hit_count(cnt_s), .cover_miss(miss_s));
  cov_counter_top #(.CNT_W(1), .SRC(cov_pkg::SRC_PULSE)) uut_bit (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_1), .seq_a(1'b0), .seq_b(1'b0),
    .eod_strobe(eod_1), .hit_count(cnt_1), .cover_miss(miss_1));

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    chk("R1 count pulse", cnt_p, 0);
    chk("R1 count seq", cnt_s, 0);
    chk("R1 miss", miss_p | miss_s | miss_1, 0);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_pulse_count();
    ev_p = 1; tick(1); ev_p = 0; tick(2);
    ev_p = 1; tick(2); ev_p = 0; tick(1);
    chk("R2 three events", cnt_p, 3);
    a_p = 1; b_p = 1; tick(3); a_p = 0; b_p = 0; tick(1);
    chk("R11 seq inputs ignored in pulse mode", cnt_p, 3);
    tick(3);
    chk("R2 idle holds", cnt_p, 3);
  endtask

  task automatic t_saturate();
    ev_p = 1; tick(4); ev_p = 0; tick(1);
    chk("R3 reaches max", cnt_p, 7);
    ev_p = 1; tick(10); ev_p = 0; tick(1);
    chk("R3 stays at max", cnt_p, 7);
    eod_p = 1; tick(1); eod_p = 0; tick(1);
    chk("R9 no miss with nonzero count", miss_p, 0);
  endtask

  task automatic t_miss();
    eod_p = 1; ev_p = 1; tick(1); eod_p = 0; ev_p = 0; tick(1);
    chk("R8 miss on zero count", miss_p, 1);
    ev_p = 1; tick(2); ev_p = 0; tick(3);
    chk("R8 miss held", miss_p, 1);
    chk("R2 counting after miss", cnt_p, 3);
    do_reset();
    chk("R10 miss cleared", miss_p, 0);
  endtask

  task automatic t_bit();
    ev_1 = 1; tick(1); ev_1 = 0; tick(1);
    chk("R4 seen bit set", cnt_1, 1);
    ev_1 = 1; tick(3); ev_1 = 0; tick(1);
    chk("R4 seen bit holds", cnt_1, 1);
    eod_1 = 1; tick(1); eod_1 = 0; tick(1);
    chk("R9 bit no miss", miss_1, 0);
  endtask

  task automatic t_seq();
    a_s = 1; tick(1); a_s = 0; b_s = 1; tick(1); b_s = 0; tick(1);
    chk("R5 single match", cnt_s, 1);
    a_s = 1; tick(1); b_s = 1; tick(1); a_s = 0; tick(1); b_s = 0; tick(1);
    chk("R6 overlapping matches", cnt_s, 3);
    a_s = 1; tick(1); a_s = 0; tick(1); b_s = 1; tick(1); b_s = 0; tick(1);
    chk("R7 gap breaks match", cnt_s, 3);
    b_s = 1; tick(1); b_s = 0; tick(1);
    chk("R7 lone second term", cnt_s, 3);
    ev_s = 1; tick(3); ev_s = 0; tick(1);
    chk("R11 pulse ignored in seq mode", cnt_s, 3);
    eod_s = 1; tick(1); eod_s = 0; tick(1);
    chk("R9 seq no miss", miss_s, 0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        done = 1'b1;
        fails++;
        $display("FAIL watchdog actual=%0d expected=<5000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    tick(1);
    do_reset();
    t_pulse_count();
    t_saturate();
    do_reset();
    t_miss();
    t_bit();
    t_seq();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule